// File: doc/BRIEF.md
# Inter-Core Set/Clear Mailbox Bank

This block stores a bank of 32-bit message words that processors use to signal each other. There are four cores with four words each. Word k of core c sits at index c*4+k. Software reaches each word through two byte addresses. Writing the first address ORs bits into the word. Writing the second address clears the bits written as one. Only the second address returns the word on a read. Several agents can therefore post and acknowledge independent flag bits without a read-modify-write sequence.

Every word drives a pending line that is high whenever the word holds any set bit. A per-core interrupt router downstream consumes these lines. Routing and masking are not part of this block. The register port takes at most one access per cycle. A read answers one cycle after it is accepted.

Top module: `ipc_mailbox_bank`

## Requirements
- R1: While reset is high, and on the cycle after it is released, all words are zero, every `box_pend` bit is low, `rd_valid` is low and `rd_data` is zero.
- R2: A write to byte address 0x80 + 4*i, for i from 0 to 15 (the set window 0x80 to 0xBF), ORs `acc_wdata` into word i. The new value is visible from the next cycle.
- R3: A write to byte address 0xC0 + 4*i (the clear window 0xC0 to 0xFF) leaves word i as word & ~`acc_wdata`. Bits written as zero are kept.
- R4: A read at 0xC0 + 4*i raises `rd_valid` for exactly the following cycle, with `rd_data` equal to word i as it stood when the read was accepted.
- R5: A read anywhere in the set window raises `rd_valid` on the following cycle with `rd_data` zero.
- R6: `box_pend[i]` is high exactly when word i is nonzero. It changes in the cycle after the write that sets or clears the last bit.
- R7: A write whose data is all zero leaves every word and every `box_pend` bit unchanged, in either window.
- R8: Accesses below 0x80 have no effect on any word. Reads there return zero with `rd_valid` set on the next cycle.
- R9: Address bits [1:0] are ignored, so 0xA7 selects the same word as 0xA4.
- R10: Word index c*4+k belongs to mailbox k of core c. For example, core 2 mailbox 1 is index 9, set at 0xA4 and cleared or read at 0xE4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 8 | Byte address of the access |
| acc_wdata | input | 32 | Write data, used as a set mask or a clear mask |
| rd_valid | output | 1 | Read data is valid this cycle |
| rd_data | output | 32 | Read data, one cycle after the read |
| box_pend | output | 16 | Per-word pending flags, bit i for word i |

## Verification
The bench builds the block with its default parameters: 4 cores, 4 words per core, 32-bit words, an 8-bit address and the set window at 0x80. With these values both windows fill the upper half of the address space exactly. Random accesses therefore reach every word through both aliases, the unmapped low half, and the two window boundaries at 0xBC/0xC0 and 0xFC. Sparse random masks let set bits build up across several writes, so partial clears are exercised and a pending flag drops only when the last bit of its word is cleared.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [2:0] {
        ACC_IDLE,
        ACC_SET,
        ACC_CLR,
        ACC_PEEK,
        ACC_VOID_RD
    } acc_kind_e;

    typedef logic [7:0] box_idx_t;

    typedef struct packed {
        acc_kind_e kind;
        box_idx_t  idx;
    } acc_t;

    function automatic logic [31:0] word_next(
        input logic [31:0] cur,
        input logic [31:0] mask,
        input acc_kind_e   kind
    );
        logic [31:0] res;
        res = cur;
        if (kind == ACC_SET) begin
            res = cur | mask;
        end else if (kind == ACC_CLR) begin
            res = cur & ~mask;
        end
        return res;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int NUM_BOX  = 16,
    parameter int SET_BASE = 'h80
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    output acc_t              acc
);
    localparam int unsigned SET_LO = SET_BASE / 4;
    localparam int unsigned CLR_LO = SET_LO + NUM_BOX;
    localparam int unsigned CLR_HI = CLR_LO + NUM_BOX;

    logic [31:0] waddr;
    logic        in_set;
    logic        in_clr;

    always_comb begin
        waddr  = 32'(acc_addr) >> 2;
        in_set = (waddr >= SET_LO) && (waddr < CLR_LO);
        in_clr = (waddr >= CLR_LO) && (waddr < CLR_HI);
        acc.kind = ACC_IDLE;
        acc.idx  = '0;
        if (in_set) begin
            acc.idx = box_idx_t'(waddr - SET_LO);
        end else if (in_clr) begin
            acc.idx = box_idx_t'(waddr - CLR_LO);
        end
        if (acc_valid) begin
            if (acc_write) begin
                if (in_set)      acc.kind = ACC_SET;
                else if (in_clr) acc.kind = ACC_CLR;
            end else begin
                acc.kind = in_clr ? ACC_PEEK : ACC_VOID_RD;
            end
        end
    end
endmodule

// File: rtl/mbx_word.sv
module mbx_word
    import mbx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MY_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  acc_t              acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word,
    output logic              pend
);
    logic hit;
    logic [31:0] nxt;

    always_comb begin
        hit = (acc.idx == box_idx_t'(MY_IDX)) &&
              (acc.kind == ACC_SET || acc.kind == ACC_CLR);
        nxt = word_next(32'(word), 32'(wdata), acc.kind);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word <= '0;
        end else if (hit) begin
            word <= nxt[DATA_W-1:0];
        end
    end

    assign pend = |word;
endmodule

// File: rtl/mbx_rdport.sv
module mbx_rdport
    import mbx_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_BOX = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  acc_t                           acc,
    input  logic [NUM_BOX-1:0][DATA_W-1:0] words,
    output logic                           rd_valid,
    output logic [DATA_W-1:0]              rd_data
);
    localparam int IDX_W = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1;

    logic [IDX_W-1:0] sel;
    assign sel = acc.idx[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= (acc.kind == ACC_PEEK) || (acc.kind == ACC_VOID_RD);
            rd_data  <= (acc.kind == ACC_PEEK) ? words[sel] : '0;
        end
    end
endmodule

// File: rtl/ipc_mailbox_bank.sv
module ipc_mailbox_bank
    import mbx_pkg::*;
#(
    parameter int NUM_CORES    = 4,
    parameter int BOX_PER_CORE = 4,
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 8,
    parameter int SET_BASE     = 'h80,
    localparam int NUM_BOX     = NUM_CORES * BOX_PER_CORE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_BOX-1:0] box_pend
);
    acc_t                           acc;
    logic [NUM_BOX-1:0][DATA_W-1:0] words;

    mbx_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_BOX (NUM_BOX),
        .SET_BASE(SET_BASE)
    ) dec_i (
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_addr (acc_addr),
        .acc      (acc)
    );

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        for (genvar k = 0; k < BOX_PER_CORE; k++) begin : g_box
            mbx_word #(
                .DATA_W(DATA_W),
                .MY_IDX(c * BOX_PER_CORE + k)
            ) word_i (
                .clk  (clk),
                .rst  (rst),
                .acc  (acc),
                .wdata(acc_wdata),
                .word (words[c*BOX_PER_CORE+k]),
                .pend (box_pend[c*BOX_PER_CORE+k])
            );
        end
    end

    mbx_rdport #(
        .DATA_W (DATA_W),
        .NUM_BOX(NUM_BOX)
    ) rd_i (
        .clk     (clk),
        .rst     (rst),
        .acc     (acc),
        .words   (words),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/mbx_bank_chk.sv
module mbx_bank_chk #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 8,
    parameter int NUM_BOX  = 16,
    parameter int SET_BASE = 'h80
) (
    input logic               clk,
    input logic               rst,
    input logic               acc_valid,
    input logic               acc_write,
    input logic [ADDR_W-1:0]  acc_addr,
    input logic [DATA_W-1:0]  acc_wdata,
    input logic               rd_valid,
    input logic [DATA_W-1:0]  rd_data,
    input logic [NUM_BOX-1:0] box_pend
);
    localparam int unsigned SLO = SET_BASE / 4;
    localparam int unsigned CLO = SLO + NUM_BOX;
    localparam int unsigned CHI = CLO + NUM_BOX;

    logic [31:0] wa;
    logic        c_set, c_clr, c_wr, c_rd, pend_sel;
    int unsigned ci;

    always_comb begin
        wa       = 32'(acc_addr) >> 2;
        c_set    = (wa >= SLO) && (wa < CLO);
        c_clr    = (wa >= CLO) && (wa < CHI);
        c_wr     = acc_valid && acc_write;
        c_rd     = acc_valid && !acc_write;
        ci       = c_set ? (wa - SLO) : (c_clr ? (wa - CLO) : 0);
        pend_sel = box_pend[ci];
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (box_pend == '0 && !rd_valid && rd_data == '0));

    a_r2_set_raises_pend: assert property (@(posedge clk) disable iff (rst)
        (c_wr && c_set && acc_wdata != '0) |=> pend_sel_q);

    a_r4_read_valid: assert property (@(posedge clk) disable iff (rst)
        c_rd |=> rd_valid);

    a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !c_rd |=> !rd_valid);

    a_r6_read_matches_pend: assert property (@(posedge clk) disable iff (rst)
        (c_rd && c_clr) |=> ((rd_data != '0) == $past(pend_sel)));

    a_r5_setwin_read_zero: assert property (@(posedge clk) disable iff (rst)
        (c_rd && !c_clr) |=> (rd_data == '0));

    a_r7_zero_write_stable: assert property (@(posedge clk) disable iff (rst)
        (c_wr && acc_wdata == '0) |=> $stable(box_pend));

    a_r8_unmapped_stable: assert property (@(posedge clk) disable iff (rst)
        (!(c_wr && (c_set || c_clr))) |=> $stable(box_pend));

    // pending bit of the word targeted by the previous cycle's access
    logic [31:0] ci_q;
    logic        pend_sel_q;
    always_ff @(posedge clk) begin
        ci_q <= 32'(ci);
    end
    assign pend_sel_q = box_pend[ci_q];
endmodule

bind ipc_mailbox_bank mbx_bank_chk #(
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .NUM_BOX (NUM_BOX),
    .SET_BASE(SET_BASE)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .acc_valid(acc_valid),
    .acc_write(acc_write),
    .acc_addr (acc_addr),
    .acc_wdata(acc_wdata),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .box_pend (box_pend)
);

// File: tb/ipc_mailbox_bank_tb.sv
module ipc_mailbox_bank_tb_top;
    localparam int NB = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic [7:0]    acc_addr = '0;
    logic [31:0]   acc_wdata = '0;
    logic          rd_valid;
    logic [31:0]   rd_data;
    logic [NB-1:0] box_pend;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] mdl [NB];
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ipc_mailbox_bank dut_i (
        .clk      (clk),
        .rst      (rst),
        .acc_valid(acc_valid),
        .acc_write(acc_write),
        .acc_addr (acc_addr),
        .acc_wdata(acc_wdata),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .box_pend (box_pend)
    );

    function automatic int win(input logic [7:0] a);
        // 1 = set window, 2 = clear window, 0 = unmapped
        if (a >= 8'h80 && a <= 8'hBF) return 1;
        if (a >= 8'hC0) return 2;
        return 0;
    endfunction

    function automatic int bidx(input logic [7:0] a);
        return int'(a[5:2]);
    endfunction

    function automatic logic [NB-1:0] exp_pend();
        logic [NB-1:0] p;
        for (int i = 0; i < NB; i++) p[i] = (mdl[i] != 0);
        return p;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_wdata = d;
        if (win(a) == 1) mdl[bidx(a)] = mdl[bidx(a)] | d;
        else if (win(a) == 2) mdl[bidx(a)] = mdl[bidx(a)] & ~d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        chk(box_pend == exp_pend(), tag, 64'(box_pend), 64'(exp_pend()));
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        logic [31:0] e;
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a;
        e = (win(a) == 2) ? mdl[bidx(a)] : 32'h0;
        @(negedge clk);
        acc_valid = 1'b0;
        chk(rd_valid && rd_data == e, tag, {31'b0, rd_valid, rd_data}, {32'b1, e});
        @(negedge clk);
        chk(!rd_valid, {tag, " single-cycle valid"}, 64'(rd_valid), 64'b0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int seed;
        logic [7:0]  a;
        logic [31:0] d;
        seed = $urandom(32'h5EED_1234);
        for (int i = 0; i < NB; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        chk(box_pend == '0 && !rd_valid && rd_data == '0, "R1 during reset",
            {box_pend, 15'b0, rd_valid, rd_data}, 64'b0);
        rst = 1'b0;
        @(negedge clk);
        chk(box_pend == '0 && !rd_valid, "R1 after release", 64'(box_pend), 64'b0);

        // R2 accumulation on word 0
        wr(8'h80, 32'h0000_0001, "R2 set word0 bit0");
        wr(8'h80, 32'h8000_0010, "R2 accumulate word0");
        rd(8'hC0, "R4 read word0 accumulated");
        // R10 core 2 mailbox 1 -> index 9
        wr(8'hA4, 32'h0000_0F00, "R10 set core2 box1");
        rd(8'hE4, "R10 read core2 box1");
        chk(box_pend == 16'h0201, "R10 pend bits 0 and 9", 64'(box_pend), 64'h0201);
        // R3 partial clear
        wr(8'hE4, 32'h0000_0300, "R3 partial clear word9");
        rd(8'hE4, "R3 word9 keeps 0xC00");
        // R7 zero writes
        wr(8'hA4, 32'h0, "R7 zero set write");
        wr(8'hE4, 32'h0, "R7 zero clear write");
        rd(8'hE4, "R7 word9 unchanged");
        // R6 last bit clears
        wr(8'hE4, 32'hFFFF_FFFF, "R6 clear all of word9");
        chk(!box_pend[9], "R6 pend9 low", 64'(box_pend[9]), 64'b0);
        // R5 set window read
        rd(8'h80, "R5 set window read zero");
        // R8 unmapped
        wr(8'h10, 32'hFFFF_FFFF, "R8 unmapped write");
        rd(8'h10, "R8 unmapped read zero");
        // R9 low bits ignored
        wr(8'hBF, 32'h0000_00A5, "R9 set via 0xBF hits word15");
        rd(8'hFE, "R9 read word15 via 0xFE");
        wr(8'hFD, 32'h0000_00A5, "R9 clear word15 via 0xFD");
        wr(8'hC3, 32'hFFFF_FFFF, "R3 clear word0 via 0xC3");

        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            r = int'($urandom_range(99));
            if (r < 40)      a = 8'h80 | 8'($urandom_range(63));
            else if (r < 85) a = 8'hC0 | 8'($urandom_range(63));
            else             a = 8'($urandom_range(255));
            d = $urandom() & $urandom() & $urandom();
            if ($urandom_range(9) == 0) d = '0;
            if ($urandom_range(2) == 0) rd(a, "R4 random read");
            else if (win(a) == 2) wr(a, d, "R3 random clear");
            else wr(a, d, "R2 random set");
        end

        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule